// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between a processor memory port and a cache controller and keeps a record of every request that has been sent to the controller but not yet answered. Each incoming request carries an address and an operation code. The block turns the operation into a primary type, which is stored, and a secondary type, which is sent to the controller. It then answers in the next cycle with one of three results: the request was issued, it collides with a request already in flight to the same cache line (aliased), or the tracker is full.

Requests fall into two classes, and each class has its own small fully associative table keyed by line address. Read-class means loads and instruction fetches. Write-class means stores, flushes, read-modify-write reads, load-linked, store-conditional and both locked read-modify-write types. A second request to a line that is already held is refused, whichever table holds it. A completion names a line and a table, frees the entry and returns the stored primary type and the latency. A watchdog flags any entry whose age reaches a configured threshold. Four saturating counters record how often each kind of collision occurred.

Top module: `lineReqTracker`

## Requirements
- R1: When the outstanding count is already at `MAX_OUT` and a request is accepted, the answer is full (code 3). No entry is added, nothing is issued and no stall counter moves.
- R2: A request that is neither full nor aliased is answered issued (code 1) and goes into the write table if its primary type is write-class (codes 2 to 8), otherwise into the read table. It is placed on the issue output with its full address.
- R3: A write-class request whose line is held in the read table or in the write table is answered aliased (code 2). The read table is checked first.
- R4: A read-class request (primary code 0 or 1) whose line is held in the write table or in the read table is answered aliased (code 2). The write table is checked first.
- R5: Four saturating counters of width `CNT_W` count alias rejections: store-on-load (write-class request, read-table hit), store-on-store, load-on-store and load-on-load. Each stops at its all-ones value.
- R6: Type codes are load 0, fetch 1, store 2, read-modify-write read 3, load-linked 4, store-conditional 5, locked read 6, locked write 7, flush 8, atomic 9. The operation codes are load 0, fetch 1, store 2, flush 3, load-linked 4, store-conditional 5, locked read 6 and locked write 7. Load-linked and store-conditional are issued as atomic. Both locked types are issued as store. A load with the store-check flag set has primary type 3 and is issued as store. Every other operation keeps the same type on both sides. The store-check flag has no effect on any other operation.
- R7: Lines are compared with the low `OFF_W` address bits ignored. Two addresses that differ only in those bits alias.
- R8: A completion that finds its line in the selected table (`cmpWrite` 1 selects the write table) frees that entry. One cycle later it reports the stored primary type and a latency equal to the number of clock edges between the insert and the completion.
- R9: A completion for a line that is not in the selected table raises `cmpMiss` with `cmpDone` and changes no table state.
- R10: A watchdog starts on an insert when no check is pending. It checks every `THRESH` cycles while requests remain. It raises the sticky `dlError` with the line of an entry whose age has reached `THRESH`. An entry inserted into an idle tracker and never completed is flagged exactly `THRESH` edges after its insert.
- R11: `outCount` always equals the number of valid entries in both tables. It is zero after reset.
- R12: `reqReady` is low while an issued request is held and `issueReady` is low. A request offered at that time is ignored (no answer), and the issue output stays stable.
- R13: Every accepted request receives exactly one answer, with `respValid`, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | ADDR_W | Request byte address |
| reqOp | input | 3 | Operation code (see R6) |
| reqStoreCheck | input | 1 | Load needs write permission |
| respValid | output | 1 | Answer to the previous accepted request |
| respCode | output | 2 | 1 issued, 2 aliased, 3 full |
| issueValid | output | 1 | Request held for the controller |
| issueReady | input | 1 | Controller takes the held request |
| issueAddr | output | ADDR_W | Address of the held request |
| issueType | output | 4 | Secondary type of the held request |
| cmpValid | input | 1 | Completion offered |
| cmpLine | input | ADDR_W-OFF_W | Line address of the completion |
| cmpWrite | input | 1 | Completion targets the write table |
| cmpDone | output | 1 | Completion result valid |
| cmpMiss | output | 1 | Completed line was not found |
| cmpType | output | 4 | Stored primary type |
| cmpLatency | output | clog2(THRESH)+2 | Edges from insert to completion |
| outCount | output | clog2(MAX_OUT+1) | Outstanding entries |
| dlError | output | 1 | Sticky stale-entry flag |
| dlLine | output | ADDR_W-OFF_W | Line of the first stale entry |
| stallStOnLd | output | CNT_W | Write-class request blocked by read entry |
| stallStOnSt | output | CNT_W | Write-class request blocked by write entry |
| stallLdOnSt | output | CNT_W | Read-class request blocked by write entry |
| stallLdOnLd | output | CNT_W | Read-class request blocked by read entry |

## Verification
Answers, issue-output contents, completion results, the outstanding count and the stall counters all change at the clock edge that accepts the stimulus. The bench drives on a falling edge and compares every one of these outputs at the next falling edge, against a table model that it updates on the same step. `reqReady` is combinational from the issue state and `issueReady`, so it is checked a moment after the inputs are driven. The watchdog flag is due exactly `THRESH` edges after the insert into an idle tracker. It is checked low on the edge before that and high on that edge.

// File: rtl/trkPkg.sv
package trkPkg;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_IFETCH = 3'd1, OP_STORE = 3'd2, OP_FLUSH = 3'd3,
    OP_LL = 3'd4, OP_SC = 3'd5, OP_LRD = 3'd6, OP_LWR = 3'd7
  } reqOpE;

  typedef enum logic [3:0] {
    T_LD = 4'd0, T_IFETCH = 4'd1, T_ST = 4'd2, T_RMWRD = 4'd3, T_LL = 4'd4,
    T_SC = 4'd5, T_LRD = 4'd6, T_LWR = 4'd7, T_FLUSH = 4'd8, T_ATOMIC = 4'd9
  } reqTypeE;

  typedef enum logic [1:0] {
    RS_NONE = 2'd0, RS_ISSUED = 2'd1, RS_ALIASED = 2'd2, RS_FULL = 2'd3
  } respE;

  localparam int SI_ST_LD = 0;
  localparam int SI_ST_ST = 1;
  localparam int SI_LD_ST = 2;
  localparam int SI_LD_LD = 3;

  typedef struct packed {
    logic       insRd;
    logic       insWr;
    logic       remRd;
    logic       remWr;
    logic [3:0] bump;
    logic       issueLoad;
    respE       resp;
    logic       cmpDone;
    logic       cmpMiss;
  } ctrlStrobeT;

endpackage

// File: rtl/trkTable.sv
module trkTable
  import trkPkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 12,
  parameter int TS_W   = 8,
  parameter int THRESH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   now,
  input  logic [LINE_W-1:0] lookLine,
  output logic              lookHit,
  input  logic [LINE_W-1:0] cmpLine,
  output logic              cmpHit,
  output reqTypeE           cmpType,
  output logic [TS_W-1:0]   cmpTs,
  input  logic              insEn,
  input  logic [LINE_W-1:0] insLine,
  input  reqTypeE           insType,
  input  logic              remEn,
  output logic              staleAny,
  output logic [LINE_W-1:0] staleLine,
  output logic [DEPTH-1:0]  validVec
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  valid;
  logic [LINE_W-1:0] line [DEPTH];
  reqTypeE           kind [DEPTH];
  logic [TS_W-1:0]   stamp[DEPTH];

  logic [DEPTH-1:0] cmpMatch;
  logic [IDX_W-1:0] freeIdx;
  logic             freeOk;

  assign validVec = valid;

  always_comb begin
    lookHit   = 1'b0;
    cmpHit    = 1'b0;
    cmpType   = T_LD;
    cmpTs     = '0;
    cmpMatch  = '0;
    freeOk    = 1'b0;
    freeIdx   = '0;
    staleAny  = 1'b0;
    staleLine = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid[i] && line[i] == lookLine) lookHit = 1'b1;
      if (valid[i] && line[i] == cmpLine) begin
        cmpHit      = 1'b1;
        cmpMatch[i] = 1'b1;
        cmpType     = kind[i];
        cmpTs       = stamp[i];
      end
      if (!valid[i] && !freeOk) begin
        freeOk  = 1'b1;
        freeIdx = IDX_W'(i);
      end
      if (valid[i] && !staleAny && (now - stamp[i]) >= TS_W'(THRESH)) begin
        staleAny  = 1'b1;
        staleLine = line[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line[i]  <= '0;
        kind[i]  <= T_LD;
        stamp[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (remEn && cmpMatch[i]) valid[i] <= 1'b0;
        if (insEn && freeIdx == IDX_W'(i)) begin
          valid[i] <= 1'b1;
          line[i]  <= insLine;
          kind[i]  <= insType;
          stamp[i] <= now;
        end
      end
    end
  end

  // R11: an insert always lands in a free slot
  a_r11_room_on_insert: assert property (@(posedge clk) disable iff (!rstN)
    insEn |-> freeOk);

endmodule

// File: rtl/trkCtrl.sv
module trkCtrl
  import trkPkg::*;
(
  input  logic       reqValid,
  input  reqOpE      reqOp,
  input  logic       reqStoreCheck,
  input  logic       lookHitRd,
  input  logic       lookHitWr,
  input  logic       full,
  input  logic       issueBusy,
  input  logic       cmpValid,
  input  logic       cmpWrite,
  input  logic       cmpHitRd,
  input  logic       cmpHitWr,
  output logic       reqReady,
  output reqTypeE    primType,
  output reqTypeE    secType,
  output ctrlStrobeT st
);
  logic isWrite;
  logic accept;
  logic cmpHit;

  always_comb begin
    unique case (reqOp)
      OP_LOAD:   begin
        primType = reqStoreCheck ? T_RMWRD : T_LD;
        secType  = reqStoreCheck ? T_ST : T_LD;
      end
      OP_IFETCH: begin primType = T_IFETCH; secType = T_IFETCH; end
      OP_STORE:  begin primType = T_ST;     secType = T_ST;     end
      OP_FLUSH:  begin primType = T_FLUSH;  secType = T_FLUSH;  end
      OP_LL:     begin primType = T_LL;     secType = T_ATOMIC; end
      OP_SC:     begin primType = T_SC;     secType = T_ATOMIC; end
      OP_LRD:    begin primType = T_LRD;    secType = T_ST;     end
      default:   begin primType = T_LWR;    secType = T_ST;     end
    endcase
  end

  assign isWrite  = (primType != T_LD) && (primType != T_IFETCH);
  assign reqReady = !issueBusy;
  assign accept   = reqValid && !issueBusy;
  assign cmpHit   = cmpWrite ? cmpHitWr : cmpHitRd;

  always_comb begin
    st = '0;
    if (accept) begin
      if (full) begin
        st.resp = RS_FULL;
      end else if (isWrite) begin
        if (lookHitRd) begin
          st.resp = RS_ALIASED;
          st.bump[SI_ST_LD] = 1'b1;
        end else if (lookHitWr) begin
          st.resp = RS_ALIASED;
          st.bump[SI_ST_ST] = 1'b1;
        end else begin
          st.resp      = RS_ISSUED;
          st.insWr     = 1'b1;
          st.issueLoad = 1'b1;
        end
      end else begin
        if (lookHitWr) begin
          st.resp = RS_ALIASED;
          st.bump[SI_LD_ST] = 1'b1;
        end else if (lookHitRd) begin
          st.resp = RS_ALIASED;
          st.bump[SI_LD_LD] = 1'b1;
        end else begin
          st.resp      = RS_ISSUED;
          st.insRd     = 1'b1;
          st.issueLoad = 1'b1;
        end
      end
    end
    st.cmpDone = cmpValid;
    st.cmpMiss = cmpValid && !cmpHit;
    st.remRd   = cmpValid && !cmpWrite && cmpHitRd;
    st.remWr   = cmpValid && cmpWrite && cmpHitWr;
  end

endmodule

// File: rtl/trkData.sv
module trkData
  import trkPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = 8,
  parameter int THRESH  = 64,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TS_W   = $clog2(THRESH) + 2,
  localparam int OC_W   = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  reqTypeE           primType,
  input  reqTypeE           secType,
  input  ctrlStrobeT        st,
  input  logic [LINE_W-1:0] cmpLine,
  input  logic              cmpWrite,
  input  logic              issueReady,
  output logic              lookHitRd,
  output logic              lookHitWr,
  output logic              cmpHitRd,
  output logic              cmpHitWr,
  output logic              full,
  output logic              issueBusy,
  output logic              respValid,
  output respE              respCode,
  output logic              issueValid,
  output logic [ADDR_W-1:0] issueAddr,
  output reqTypeE           issueType,
  output logic              cmpDone,
  output logic              cmpMiss,
  output reqTypeE           cmpType,
  output logic [TS_W-1:0]   cmpLatency,
  output logic [OC_W-1:0]   outCount,
  output logic              dlError,
  output logic [LINE_W-1:0] dlLine,
  output logic [CNT_W-1:0]  stallCnt [4]
);
  logic [LINE_W-1:0] reqLine;
  logic [TS_W-1:0]   nowCnt;
  logic [1:0]        lookHitV, cmpHitV, staleV, insV, remV;
  reqTypeE           tType [2];
  logic [TS_W-1:0]   tTs   [2];
  logic [LINE_W-1:0] staleL[2];
  logic [MAX_OUT-1:0] vVec [2];
  logic [OC_W-1:0]   cntNext;
  logic [TS_W-1:0]   wdCnt;
  logic              wdArmed, wdFire;

  assign reqLine = reqAddr[ADDR_W-1:OFF_W];
  assign insV    = {st.insWr, st.insRd};
  assign remV    = {st.remWr, st.remRd};

  // index 0 holds read-class entries, index 1 write-class entries
  for (genvar g = 0; g < 2; g++) begin : gTab
    trkTable #(.DEPTH(MAX_OUT), .LINE_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH)) uTab (
      .clk(clk), .rstN(rstN), .now(nowCnt),
      .lookLine(reqLine), .lookHit(lookHitV[g]),
      .cmpLine(cmpLine), .cmpHit(cmpHitV[g]), .cmpType(tType[g]), .cmpTs(tTs[g]),
      .insEn(insV[g]), .insLine(reqLine), .insType(primType), .remEn(remV[g]),
      .staleAny(staleV[g]), .staleLine(staleL[g]), .validVec(vVec[g])
    );
  end

  assign lookHitRd = lookHitV[0];
  assign lookHitWr = lookHitV[1];
  assign cmpHitRd  = cmpHitV[0];
  assign cmpHitWr  = cmpHitV[1];
  assign full      = outCount >= OC_W'(MAX_OUT);
  assign issueBusy = issueValid && !issueReady;
  assign cntNext   = outCount + OC_W'(st.insRd | st.insWr) - OC_W'(st.remRd | st.remWr);
  assign wdFire    = wdArmed && (wdCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowCnt     <= '0;
      outCount   <= '0;
      respValid  <= 1'b0;
      respCode   <= RS_NONE;
      issueValid <= 1'b0;
      issueAddr  <= '0;
      issueType  <= T_LD;
      cmpDone    <= 1'b0;
      cmpMiss    <= 1'b0;
      cmpType    <= T_LD;
      cmpLatency <= '0;
      wdArmed    <= 1'b0;
      wdCnt      <= '0;
      dlError    <= 1'b0;
      dlLine     <= '0;
    end else begin
      nowCnt    <= nowCnt + 1'b1;
      outCount  <= cntNext;
      respValid <= (st.resp != RS_NONE);
      respCode  <= st.resp;
      if (st.issueLoad) begin
        issueValid <= 1'b1;
        issueAddr  <= reqAddr;
        issueType  <= secType;
      end else if (issueReady) begin
        issueValid <= 1'b0;
      end
      cmpDone    <= st.cmpDone;
      cmpMiss    <= st.cmpMiss;
      cmpType    <= (st.cmpDone && !st.cmpMiss) ? tType[cmpWrite] : T_LD;
      cmpLatency <= (st.cmpDone && !st.cmpMiss) ? nowCnt - tTs[cmpWrite] : '0;
      if (wdFire) begin
        wdArmed <= (cntNext != '0);
        wdCnt   <= TS_W'(THRESH - 1);
        if (!dlError && (staleV != 2'b00)) begin
          dlError <= 1'b1;
          dlLine  <= staleV[0] ? staleL[0] : staleL[1];
        end
      end else if (!wdArmed && (insV != 2'b00)) begin
        wdArmed <= 1'b1;
        wdCnt   <= TS_W'(THRESH - 1);
      end else if (wdArmed) begin
        wdCnt <= wdCnt - 1'b1;
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : gStall
    always_ff @(posedge clk) begin
      if (!rstN) stallCnt[k] <= '0;
      else if (st.bump[k] && (stallCnt[k] != '1)) stallCnt[k] <= stallCnt[k] + 1'b1;
    end
    // R5: stall counters never wrap back down
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> stallCnt[k] >= $past(stallCnt[k]));
  end

  a_r11_count_matches_tables: assert property (@(posedge clk) disable iff (!rstN)
    32'(outCount) == $countones(vVec[0]) + $countones(vVec[1]));

  // R4 as well: one line never sits in both tables
  a_r3_line_in_one_table: assert property (@(posedge clk) disable iff (!rstN)
    !(lookHitRd && lookHitWr));

  a_r1_full_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (st.resp == RS_FULL && !st.remRd && !st.remWr) |=> $stable(outCount));

  a_r12_issue_held: assert property (@(posedge clk) disable iff (!rstN)
    issueBusy |=> issueValid && $stable(issueAddr) && $stable(issueType));

  a_r13_answer_next: assert property (@(posedge clk) disable iff (!rstN)
    (st.resp != RS_NONE) |=> respValid);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dlError |=> dlError && $stable(dlLine));

endmodule

// File: rtl/lineReqTracker.sv
module lineReqTracker
  import trkPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = 8,
  parameter int THRESH  = 64,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TS_W   = $clog2(THRESH) + 2,
  localparam int OC_W   = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqOp,
  input  logic              reqStoreCheck,
  output logic              respValid,
  output logic [1:0]        respCode,
  output logic              issueValid,
  input  logic              issueReady,
  output logic [ADDR_W-1:0] issueAddr,
  output logic [3:0]        issueType,
  input  logic              cmpValid,
  input  logic [LINE_W-1:0] cmpLine,
  input  logic              cmpWrite,
  output logic              cmpDone,
  output logic              cmpMiss,
  output logic [3:0]        cmpType,
  output logic [TS_W-1:0]   cmpLatency,
  output logic [OC_W-1:0]   outCount,
  output logic              dlError,
  output logic [LINE_W-1:0] dlLine,
  output logic [CNT_W-1:0]  stallStOnLd,
  output logic [CNT_W-1:0]  stallStOnSt,
  output logic [CNT_W-1:0]  stallLdOnSt,
  output logic [CNT_W-1:0]  stallLdOnLd
);
  ctrlStrobeT       st;
  reqTypeE          primType, secType, issueTypeE, cmpTypeE;
  respE             respE_q;
  logic             lookHitRd, lookHitWr, cmpHitRd, cmpHitWr, full, issueBusy;
  logic [CNT_W-1:0] stallCnt [4];

  trkCtrl uCtrl (
    .reqValid(reqValid), .reqOp(reqOpE'(reqOp)), .reqStoreCheck(reqStoreCheck),
    .lookHitRd(lookHitRd), .lookHitWr(lookHitWr), .full(full), .issueBusy(issueBusy),
    .cmpValid(cmpValid), .cmpWrite(cmpWrite), .cmpHitRd(cmpHitRd), .cmpHitWr(cmpHitWr),
    .reqReady(reqReady), .primType(primType), .secType(secType), .st(st)
  );

  trkData #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W),
            .THRESH(THRESH)) uData (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .primType(primType), .secType(secType),
    .st(st), .cmpLine(cmpLine), .cmpWrite(cmpWrite), .issueReady(issueReady),
    .lookHitRd(lookHitRd), .lookHitWr(lookHitWr), .cmpHitRd(cmpHitRd), .cmpHitWr(cmpHitWr),
    .full(full), .issueBusy(issueBusy), .respValid(respValid), .respCode(respE_q),
    .issueValid(issueValid), .issueAddr(issueAddr), .issueType(issueTypeE),
    .cmpDone(cmpDone), .cmpMiss(cmpMiss), .cmpType(cmpTypeE), .cmpLatency(cmpLatency),
    .outCount(outCount), .dlError(dlError), .dlLine(dlLine), .stallCnt(stallCnt)
  );

  assign respCode    = respE_q;
  assign issueType   = issueTypeE;
  assign cmpType     = cmpTypeE;
  assign stallStOnLd = stallCnt[SI_ST_LD];
  assign stallStOnSt = stallCnt[SI_ST_ST];
  assign stallLdOnSt = stallCnt[SI_LD_ST];
  assign stallLdOnLd = stallCnt[SI_LD_LD];

endmodule

// File: tb/lineReqTracker_test.sv
module lineReqTracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXO = 4;
  localparam int THR  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqStoreCheck = 1'b0, issueReady = 1'b1;
  logic cmpValid = 1'b0, cmpWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [2:0]  reqOp = '0;
  logic [11:0] cmpLine = '0;
  logic reqReady, respValid, issueValid, cmpDone, cmpMiss, dlError;
  logic [1:0] respCode;
  logic [15:0] issueAddr;
  logic [3:0] issueType, cmpType;
  logic [7:0] cmpLatency;
  logic [2:0] outCount;
  logic [11:0] dlLine;
  logic [7:0] stallStOnLd, stallStOnSt, stallLdOnSt, stallLdOnLd;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineReqTracker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqOp(reqOp), .reqStoreCheck(reqStoreCheck), .respValid(respValid), .respCode(respCode),
    .issueValid(issueValid), .issueReady(issueReady), .issueAddr(issueAddr),
    .issueType(issueType), .cmpValid(cmpValid), .cmpLine(cmpLine), .cmpWrite(cmpWrite),
    .cmpDone(cmpDone), .cmpMiss(cmpMiss), .cmpType(cmpType), .cmpLatency(cmpLatency),
    .outCount(outCount), .dlError(dlError), .dlLine(dlLine), .stallStOnLd(stallStOnLd),
    .stallStOnSt(stallStOnSt), .stallLdOnSt(stallLdOnSt), .stallLdOnLd(stallLdOnLd)
  );

  int nChk = 0, nFail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench model of both tables: [0] read-class, [1] write-class
  bit  mV [2][MAXO];
  int  mL [2][MAXO];
  int  mT [2][MAXO];
  int  mC [2][MAXO];
  int  mStall [4];
  bit  mIssV; int mIssA, mIssT;
  bit  eRespV; int eResp; string eTag;
  bit  eCmpV, eMiss; int eCmpT, eLat;
  bit  eDl; int eDlLine;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int primOf(input int op, input bit sc);
    case (op)
      0: return sc ? 3 : 0;
      1: return 1;
      2: return 2;
      3: return 8;
      4: return 4;
      5: return 5;
      6: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic int secOf(input int op, input bit sc);
    case (op)
      0: return sc ? 2 : 0;
      1: return 1;
      2: return 2;
      3: return 8;
      4, 5: return 9;
      default: return 2;
    endcase
  endfunction

  function automatic int findT(input int t, input int line);
    for (int i = 0; i < MAXO; i++) if (mV[t][i] && mL[t][i] == line) return i;
    return -1;
  endfunction

  function automatic int countM();
    int n = 0;
    for (int t = 0; t < 2; t++) for (int i = 0; i < MAXO; i++) n += mV[t][i];
    return n;
  endfunction

  function automatic void bump(input int k);
    if (mStall[k] < 255) mStall[k]++;
  endfunction

  task automatic clearModel();
    for (int t = 0; t < 2; t++) for (int i = 0; i < MAXO; i++) mV[t][i] = 0;
    for (int k = 0; k < 4; k++) mStall[k] = 0;
    mIssV = 0; eRespV = 0; eCmpV = 0; eDl = 0;
  endtask

  task automatic checkOut();
    chk(respValid === eRespV, "R13", respValid, eRespV);
    if (eRespV) chk(respCode === eResp[1:0], eTag, respCode, eResp);
    chk(issueValid === mIssV, "R12", issueValid, mIssV);
    if (mIssV) begin
      chk(issueType === mIssT[3:0], "R6", issueType, mIssT);
      chk(issueAddr === mIssA[15:0], "R2", issueAddr, mIssA);
    end
    chk(cmpDone === eCmpV, "R8", cmpDone, eCmpV);
    if (eCmpV) begin
      chk(cmpMiss === eMiss, "R9", cmpMiss, eMiss);
      if (!eMiss) begin
        chk(cmpType === eCmpT[3:0], "R8", cmpType, eCmpT);
        chk(cmpLatency === eLat[7:0], "R8", cmpLatency, eLat);
      end
    end
    chk(outCount === countM(), "R11", outCount, countM());
    chk(stallStOnLd === mStall[0], "R5", stallStOnLd, mStall[0]);
    chk(stallStOnSt === mStall[1], "R5", stallStOnSt, mStall[1]);
    chk(stallLdOnSt === mStall[2], "R5", stallLdOnSt, mStall[2]);
    chk(stallLdOnLd === mStall[3], "R5", stallLdOnLd, mStall[3]);
    chk(dlError === eDl, "R10", dlError, eDl);
    if (eDl) chk(dlLine === eDlLine[11:0], "R10", dlLine, eDlLine);
  endtask

  // drive one cycle at a falling edge, predict, then check at the next falling edge
  task automatic cycle(input bit rv, input int op, input bit sc, input int addr,
                       input bit cv, input int cl, input bit cw, input bit rdy);
    int line, p, s, hr, hw, insT, idx;
    bit acc, expRdy;
    reqValid = rv; reqOp = op[2:0]; reqStoreCheck = sc; reqAddr = addr[15:0];
    cmpValid = cv; cmpLine = cl[11:0]; cmpWrite = cw; issueReady = rdy;
    #1;
    expRdy = !(mIssV && !rdy);
    chk(reqReady === expRdy, "R12", reqReady, expRdy);
    acc = rv && expRdy;
    line = addr >> 4;
    p = primOf(op, sc); s = secOf(op, sc);
    hr = findT(0, line); hw = findT(1, line);
    insT = -1; eRespV = acc; eResp = 0; eTag = "R13";
    if (acc) begin
      if (countM() >= MAXO) begin eResp = 3; eTag = "R1"; end
      else if (p >= 2 && p <= 8) begin
        if (hr >= 0) begin eResp = 2; bump(0); eTag = "R3"; end
        else if (hw >= 0) begin eResp = 2; bump(1); eTag = "R3"; end
        else begin eResp = 1; insT = 1; eTag = "R2"; end
      end else begin
        if (hw >= 0) begin eResp = 2; bump(2); eTag = "R4"; end
        else if (hr >= 0) begin eResp = 2; bump(3); eTag = "R4"; end
        else begin eResp = 1; insT = 0; eTag = "R2"; end
      end
    end
    eCmpV = cv;
    if (cv) begin
      idx = findT(int'(cw), cl);
      eMiss = (idx < 0);
      if (!eMiss) begin
        eCmpT = mT[cw][idx]; eLat = (cyc - mC[cw][idx]) & 255;
        mV[cw][idx] = 0;
      end
    end
    if (insT >= 0) begin
      for (int i = 0; i < MAXO; i++) if (!mV[insT][i]) begin
        mV[insT][i] = 1; mL[insT][i] = line; mT[insT][i] = p; mC[insT][i] = cyc;
        break;
      end
    end
    if (acc && eResp == 1) begin mIssV = 1; mIssA = addr; mIssT = s; end
    else if (rdy) mIssV = 0;
    @(negedge clk);
    checkOut();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 0; cmpValid = 0; issueReady = 1;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    clearModel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clearModel();
    doReset();
    // reset state
    chk(outCount === 0, "R11", outCount, 0);
    chk(respValid === 0, "R13", respValid, 0);
    chk(issueValid === 0, "R12", issueValid, 0);
    chk(dlError === 0, "R10", dlError, 0);
    chk(stallLdOnLd === 0, "R5", stallLdOnLd, 0);

    // R6: type mapping for every operation, each issued then completed
    for (int op = 0; op < 8; op++) begin
      for (int sc = 0; sc < 2; sc++) begin
        int p;
        p = primOf(op, sc[0]);
        cycle(1, op, sc[0], 16'h4000 + op * 16, 0, 0, 0, 1);
        cycle(0, 0, 0, 0, 1, 12'h400 + op, (p >= 2), 1);
      end
    end

    // R7: offsets inside a line alias
    cycle(1, 0, 0, 16'h1230, 0, 0, 0, 1);
    cycle(1, 1, 0, 16'h123F, 0, 0, 0, 1);
    chk(respCode === 2'd2, "R7", respCode, 2);
    cycle(1, 2, 0, 16'h1238, 0, 0, 0, 1);  // store on held read line
    cycle(0, 0, 0, 0, 1, 12'h123, 0, 1);
    cycle(1, 4, 0, 16'h1230, 0, 0, 0, 1);  // load-linked into write table
    cycle(1, 0, 0, 16'h1234, 0, 0, 0, 1);  // load on held write line
    cycle(1, 3, 0, 16'h1231, 0, 0, 0, 1);  // flush on held write line
    cycle(0, 0, 0, 0, 1, 12'h123, 1, 1);

    // R1: fill to the limit, then one more
    for (int i = 0; i < MAXO; i++) cycle(1, 0, 0, 16'h2000 + i * 16, 0, 0, 0, 1);
    cycle(1, 2, 0, 16'h2100, 0, 0, 0, 1);
    chk(respCode === 2'd3, "R1", respCode, 3);
    chk(outCount === 3'(MAXO), "R1", outCount, MAXO);
    for (int i = 0; i < MAXO; i++) cycle(0, 0, 0, 0, 1, 12'h200 + i, 0, 1);

    // R9: completion for an absent line, and for the wrong table
    cycle(0, 0, 0, 0, 1, 12'h3FF, 1, 1);
    chk(cmpMiss === 1'b1, "R9", cmpMiss, 1);
    cycle(1, 0, 0, 16'h3EE0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 12'h3EE, 1, 1);
    chk(outCount === 3'd1, "R9", outCount, 1);
    cycle(0, 0, 0, 0, 1, 12'h3EE, 0, 1);

    // R12: backpressure on the issue output
    cycle(1, 0, 0, 16'h3000, 0, 0, 0, 0);
    cycle(1, 0, 0, 16'h3010, 0, 0, 0, 0);
    chk(respValid === 1'b0, "R12", respValid, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 1);
    cycle(1, 0, 0, 16'h3010, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1, 12'h300, 0, 1);
    cycle(0, 0, 0, 0, 1, 12'h301, 0, 1);

    // R5: saturation of the load-on-load counter
    for (int k = 0; k < 300; k++) cycle(1, 0, 0, 16'h5000, (k % 30 == 29), 12'h500, 0, 1);
    chk(stallLdOnLd === 8'hFF, "R5", stallLdOnLd, 255);
    cycle(0, 0, 0, 0, 1, 12'h500, 0, 1);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit rv, cv, cw, sc, rdy; int op, addr, cl;
      rv = ($urandom_range(0, 99) < 60);
      op = $urandom_range(0, 7);
      sc = $urandom_range(0, 1);
      addr = ((12'h100 + $urandom_range(0, 5)) << 4) | $urandom_range(0, 15);
      rdy = ($urandom_range(0, 99) < 80);
      cv = 0; cw = 0; cl = 0;
      for (int t = 0; t < 2; t++) for (int i = 0; i < MAXO; i++)
        if (!cv && mV[t][i] && (cyc - mC[t][i]) >= 40) begin
          cv = 1; cw = t[0]; cl = mL[t][i];
        end
      if (!cv && $urandom_range(0, 99) < 45) begin
        cv = 1; cw = $urandom_range(0, 1);
        cl = 12'h100 + $urandom_range(0, 6);
      end
      cycle(rv, op, sc, addr, cv, cl, cw, rdy);
    end

    // R10: stale entry in an otherwise idle tracker
    doReset();
    @(negedge clk);
    cycle(1, 2, 0, 16'h0770, 0, 0, 0, 1);
    for (int k = 1; k <= THR; k++) begin
      if (k == THR) begin eDl = 1; eDlLine = 12'h077; end
      cycle(0, 0, 0, 0, 0, 0, 0, 1);
      if (k == THR - 1) chk(dlError === 1'b0, "R10", dlError, 0);
    end
    chk(dlError === 1'b1 && dlLine === 12'h077, "R10", dlLine, 12'h077);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule